// File: doc/BRIEF.md
# History Path Candidate Scanner

This block screens a stream of stored travel paths against one route query. The query gives a start node, an end node and the hop count of the geometric shortest path between them. A host-side slack value widens that hop limit. The block reads the stored paths once, strictly in arrival order. It keeps every path that begins at the query start node, finishes at the query end node and uses no more edges than the widened limit. For every kept path it streams out the edges in order. At the end of the pass it reports how many paths were kept.

The paths arrive as a valid/ready stream of node identifiers. A first-beat flag and a last-beat flag frame each path. A tail flag on the last beat marks the final stored path. The nodes of the current path are held in a local buffer while they arrive. The edges go out only once the last beat has confirmed the end node. A path that fails is dropped without any output. When no stored path qualifies, the block raises a flag in the done cycle so that the caller uses the shortest path as the only candidate instead.

Top module: `hist_path_scanner`

## Requirements
- R1: A path is kept only when its first node (the beat with `s_first`=1) equals the query start node.
- R2: A path is kept only when its last node (the beat with `s_last`=1) equals the query end node.
- R3: A path is kept only when its edge count (node count minus one) is no greater than `q_sp_hops` plus the slack. Both values are captured on the cycle that `q_start` is accepted, so later changes to `cfg_slack` have no effect on that pass.
- R4: A path with more than `MAX_HOPS` edges (31 by default) is never kept, even when the hop limit from R3 is larger.
- R5: For each kept path, the edges leave in path order as (`e_from`, `e_to`) = (node i, node i+1). `e_last`=1 marks the final edge of the path. A kept path with a single node is counted but produces no edges.
- R6: A rejected path produces no edge output. The input is never stalled inside a path, and it is ready again on the cycle after the last beat of a rejected path.
- R7: While a kept path's edges are being delivered, `s_ready` is low. An edge that is offered and not taken keeps `e_valid` high and its fields unchanged.
- R8: `pass_done` is a one-cycle pulse. It comes one cycle after the final beat when no edges are pending, or one cycle after the last edge is taken otherwise. In that cycle `cand_count` equals the number of kept paths, and `use_shortest` is 1 exactly when that number is zero.
- R9: After reset and after each done pulse, the block is idle with `s_ready` low and no output. A `q_start` pulse makes it ready on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slack | input | SLACK_W | Host-set extra hops allowed beyond the shortest path |
| q_start | input | 1 | Starts a pass with the query below (taken only when idle) |
| q_src | input | NODE_W | Query start node |
| q_dst | input | NODE_W | Query end node |
| q_sp_hops | input | HOP_W | Edge count of the shortest path |
| s_valid | input | 1 | Stored-path beat valid |
| s_ready | output | 1 | Scanner accepts a beat |
| s_node | input | NODE_W | Node identifier of the beat |
| s_first | input | 1 | Beat is the first node of a path |
| s_last | input | 1 | Beat is the last node of a path |
| s_tail | input | 1 | With `s_last`: this path is the final one of the store |
| e_valid | output | 1 | Edge of a kept path is offered |
| e_ready | input | 1 | Downstream takes the edge |
| e_from | output | NODE_W | Edge origin node |
| e_to | output | NODE_W | Edge destination node |
| e_last | output | 1 | Final edge of the current kept path |
| pass_done | output | 1 | One-cycle end-of-pass pulse |
| cand_count | output | CNT_W | Number of kept paths in the pass |
| use_shortest | output | 1 | In the done cycle: no path was kept |

## Verification
The hardest case to reach is a path that stays valid on every beat but one. Examples are a path whose edge count equals the widened limit exactly and one a single edge over it. The hard cap case is also difficult: the query limit exceeds the buffer depth and the path is one edge longer than the buffer holds. The stimulus builds these paths from a node-count parameter around the limit. In one pass it changes `cfg_slack` right after the query is taken, which shows that the latched value governs. Back-pressure on the edge port is randomised so that a drain overlaps the next path's first beat. This exercises the stall at the input and the stable hold of an edge that has not been taken.

// File: rtl/hps_pkg.sv
package hps_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } scan_state_e;

endpackage

// File: rtl/hps_path_judge.sv
// Per-beat judgement of the path that is streaming in: position, liveness, final keep.
module hps_path_judge #(
   parameter int NODE_W   = 16,
   parameter int HOP_W    = 6,
   parameter int MAX_HOPS = 31
) (
   input  logic [NODE_W-1:0] node,
   input  logic              first,
   input  logic              last,
   input  logic [HOP_W-1:0]  pos_q,
   input  logic              alive_q,
   input  logic [NODE_W-1:0] want_src,
   input  logic [NODE_W-1:0] want_dst,
   input  logic [HOP_W-1:0]  hop_lim,
   output logic [HOP_W-1:0]  pos_d,
   output logic              alive_d,
   output logic              keep
);

   localparam logic [HOP_W-1:0] POS_SAT = HOP_W'(MAX_HOPS + 1);

   always_comb begin
      if (first) begin
         pos_d = '0;
      end else if (pos_q == POS_SAT) begin
         pos_d = POS_SAT;
      end else begin
         pos_d = pos_q + 1'b1;
      end
   end

   // A path dies at its first node on a start mismatch, or as soon as its edge count passes the limit.
   always_comb begin
      if (first) begin
         alive_d = (node == want_src);
      end else begin
         alive_d = alive_q && (pos_d <= hop_lim);
      end
   end

   assign keep = last && alive_d && (node == want_dst);

endmodule

// File: rtl/hps_node_buf.sv
// Holds the nodes of the path in flight; two read taps give one edge per cycle.
module hps_node_buf #(
   parameter int NODE_W = 16,
   parameter int DEPTH  = 32,
   parameter int AW     = 5
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_idx,
   input  logic [NODE_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   output logic [NODE_W-1:0] rd_a,
   output logic [NODE_W-1:0] rd_b
);

   logic [NODE_W-1:0] slot_q [DEPTH];
   logic [AW-1:0]     rd_idx_nx;

   assign rd_idx_nx = rd_idx + 1'b1;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         slot_q[wr_idx] <= wr_data;
      end
   end

   always_comb begin
      rd_a = '0;
      rd_b = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (AW'(i) == rd_idx) begin
            rd_a = slot_q[i];
         end
         if (AW'(i) == rd_idx_nx) begin
            rd_b = slot_q[i];
         end
      end
   end

endmodule

// File: rtl/hist_path_scanner.sv
module hist_path_scanner
   import hps_pkg::*;
#(
   parameter int NODE_W   = 16,
   parameter int MAX_HOPS = 31,
   parameter int HOP_W    = 6,
   parameter int SLACK_W  = 4,
   parameter int CNT_W    = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SLACK_W-1:0] cfg_slack,
   input  logic               q_start,
   input  logic [NODE_W-1:0]  q_src,
   input  logic [NODE_W-1:0]  q_dst,
   input  logic [HOP_W-1:0]   q_sp_hops,
   input  logic               s_valid,
   output logic               s_ready,
   input  logic [NODE_W-1:0]  s_node,
   input  logic               s_first,
   input  logic               s_last,
   input  logic               s_tail,
   output logic               e_valid,
   input  logic               e_ready,
   output logic [NODE_W-1:0]  e_from,
   output logic [NODE_W-1:0]  e_to,
   output logic               e_last,
   output logic               pass_done,
   output logic [CNT_W-1:0]   cand_count,
   output logic               use_shortest
);

   localparam int DEPTH = MAX_HOPS + 1;
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SUM_W = ((HOP_W > SLACK_W) ? HOP_W : SLACK_W) + 1;

   // Elaboration-time parameter checks
   if (MAX_HOPS < 1) begin : g_bad_max_hops
      $error("hist_path_scanner: MAX_HOPS must be at least 1");
   end
   if ((2 ** HOP_W) <= (MAX_HOPS + 1)) begin : g_bad_hop_w
      $error("hist_path_scanner: HOP_W too narrow to hold MAX_HOPS+1");
   end
   if (SLACK_W < 1 || CNT_W < 1 || NODE_W < 1) begin : g_bad_widths
      $error("hist_path_scanner: widths must be positive");
   end

   scan_state_e       state_q;
   logic [NODE_W-1:0] src_q, dst_q;
   logic [HOP_W-1:0]  lim_q;
   logic [HOP_W-1:0]  pos_q;
   logic              alive_q;
   logic [AW-1:0]     len_q, rd_q;
   logic              tail_q;
   logic              any_q;
   logic [CNT_W-1:0]  cnt_q;

   logic [SUM_W-1:0]  bound_sum;
   logic [HOP_W-1:0]  pos_d;
   logic              alive_d, keep;
   logic              beat, edge_take, edge_end;
   logic [AW-1:0]     rd_nx;

   assign bound_sum = SUM_W'(q_sp_hops) + SUM_W'(cfg_slack);

   hps_path_judge #(
      .NODE_W   (NODE_W),
      .HOP_W    (HOP_W),
      .MAX_HOPS (MAX_HOPS)
   ) u_judge (
      .node     (s_node),
      .first    (s_first),
      .last     (s_last),
      .pos_q    (pos_q),
      .alive_q  (alive_q),
      .want_src (src_q),
      .want_dst (dst_q),
      .hop_lim  (lim_q),
      .pos_d    (pos_d),
      .alive_d  (alive_d),
      .keep     (keep)
   );

   hps_node_buf #(
      .NODE_W (NODE_W),
      .DEPTH  (DEPTH),
      .AW     (AW)
   ) u_buf (
      .clk     (clk),
      .wr_en   (beat && alive_d),
      .wr_idx  (pos_d[AW-1:0]),
      .wr_data (s_node),
      .rd_idx  (rd_q),
      .rd_a    (e_from),
      .rd_b    (e_to)
   );

   assign s_ready      = (state_q == ST_SCAN);
   assign beat         = s_valid && s_ready;
   assign e_valid      = (state_q == ST_DRAIN);
   assign rd_nx        = rd_q + 1'b1;
   assign edge_end     = (rd_nx == len_q);
   assign e_last       = e_valid && edge_end;
   assign edge_take    = e_valid && e_ready;
   assign pass_done    = (state_q == ST_DONE);
   assign cand_count   = cnt_q;
   assign use_shortest = pass_done && !any_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         lim_q   <= '0;
         pos_q   <= '0;
         alive_q <= 1'b0;
         len_q   <= '0;
         rd_q    <= '0;
         tail_q  <= 1'b0;
         any_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (q_start) begin
                  src_q   <= q_src;
                  dst_q   <= q_dst;
                  lim_q   <= (bound_sum > SUM_W'(MAX_HOPS)) ? HOP_W'(MAX_HOPS)
                                                             : HOP_W'(bound_sum);
                  pos_q   <= '0;
                  alive_q <= 1'b0;
                  tail_q  <= 1'b0;
                  any_q   <= 1'b0;
                  cnt_q   <= '0;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (beat) begin
                  pos_q   <= pos_d;
                  alive_q <= alive_d;
                  if (s_last && s_tail) begin
                     tail_q <= 1'b1;
                  end
                  if (keep) begin
                     cnt_q <= cnt_q + 1'b1;
                     any_q <= 1'b1;
                  end
                  if (keep && (pos_d != '0)) begin
                     len_q   <= pos_d[AW-1:0];
                     rd_q    <= '0;
                     state_q <= ST_DRAIN;
                  end else if (s_last && s_tail) begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DRAIN: begin
               if (edge_take) begin
                  rd_q <= rd_nx;
                  if (edge_end) begin
                     state_q <= tail_q ? ST_DONE : ST_SCAN;
                  end
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
   parameter int NODE_W = 16,
   parameter int CNT_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic              e_valid,
   input logic              e_ready,
   input logic [NODE_W-1:0] e_from,
   input logic [NODE_W-1:0] e_to,
   input logic              e_last,
   input logic              pass_done,
   input logic [CNT_W-1:0]  cand_count,
   input logic              use_shortest
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done) else $error("done pulse longer than one cycle"); // R8

   AST_FALLBACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> (use_shortest == (cand_count == '0))) else $error("fallback disagrees with count"); // R8

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cand_count) |-> ((cand_count == $past(cand_count) + 1'b1) || (cand_count == '0)))
      else $error("candidate count jumped"); // R8

   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && !e_ready) |=> (e_valid && $stable(e_from) && $stable(e_to) && $stable(e_last)))
      else $error("offered edge changed before it was taken"); // R7

   AST_EDGE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_ready && !e_last) |=> (e_valid && (e_from == $past(e_to))))
      else $error("consecutive edges do not share a node"); // R5

   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> (!s_ready && !e_valid)) else $error("activity after done"); // R9

endmodule

bind hist_path_scanner hps_checker #(
   .NODE_W (NODE_W),
   .CNT_W  (CNT_W)
) u_hps_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .s_ready      (s_ready),
   .e_valid      (e_valid),
   .e_ready      (e_ready),
   .e_from       (e_from),
   .e_to         (e_to),
   .e_last       (e_last),
   .pass_done    (pass_done),
   .cand_count   (cand_count),
   .use_shortest (use_shortest)
);

// File: tb/hist_path_scanner_bench.sv
module hist_path_scanner_bench;

   localparam int NODE_W   = 16;
   localparam int MAX_HOPS = 31;
   localparam int HOP_W    = 6;
   localparam int SLACK_W  = 4;
   localparam int CNT_W    = 12;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n = 1'b0;
   logic [SLACK_W-1:0] cfg_slack = '0;
   logic               q_start = 1'b0;
   logic [NODE_W-1:0]  q_src = '0, q_dst = '0;
   logic [HOP_W-1:0]   q_sp_hops = '0;
   logic               s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0, s_tail = 1'b0;
   logic [NODE_W-1:0]  s_node = '0;
   logic               s_ready;
   logic               e_valid, e_last;
   logic               e_ready = 1'b0;
   logic [NODE_W-1:0]  e_from, e_to;
   logic               pass_done, use_shortest;
   logic [CNT_W-1:0]   cand_count;

   hist_path_scanner #(
      .NODE_W(NODE_W), .MAX_HOPS(MAX_HOPS), .HOP_W(HOP_W), .SLACK_W(SLACK_W), .CNT_W(CNT_W)
   ) u_hist_path_scanner (
      .clk(clk), .rst_n(rst_n), .cfg_slack(cfg_slack), .q_start(q_start),
      .q_src(q_src), .q_dst(q_dst), .q_sp_hops(q_sp_hops),
      .s_valid(s_valid), .s_ready(s_ready), .s_node(s_node), .s_first(s_first),
      .s_last(s_last), .s_tail(s_tail),
      .e_valid(e_valid), .e_ready(e_ready), .e_from(e_from), .e_to(e_to), .e_last(e_last),
      .pass_done(pass_done), .cand_count(cand_count), .use_shortest(use_shortest)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int exp_from[$];
   int exp_to[$];
   int exp_last[$];
   int exp_cnt = 0;
   int m_src = 0, m_dst = 0, m_lim = 0;
   bit done_seen = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Output monitor: decides e_ready for the coming edge, then compares what that edge will carry.
   always @(negedge clk) begin
      if (rst_n) begin
         e_ready = ($urandom_range(0, 3) != 0);
         if (e_valid) begin
            chk(!s_ready, "R7", "input ready during drain", int'(s_ready), 0);
         end
         if (e_valid && e_ready) begin
            if (exp_from.size() == 0) begin
               chk(1'b0, "R6", "edge from a rejected path", int'(e_from), -1);
            end else begin
               int f, t, l;
               f = exp_from.pop_front();
               t = exp_to.pop_front();
               l = exp_last.pop_front();
               chk(int'(e_from) == f, "R5", "edge origin", int'(e_from), f);
               chk(int'(e_to) == t, "R5", "edge destination", int'(e_to), t);
               chk(int'(e_last) == l, "R5", "last-edge flag", int'(e_last), l);
            end
         end
         if (pass_done) begin
            chk(int'(cand_count) == exp_cnt, "R8", "candidate count", int'(cand_count), exp_cnt);
            chk(use_shortest == (exp_cnt == 0), "R8", "fallback flag",
                int'(use_shortest), int'(exp_cnt == 0));
            chk(exp_from.size() == 0, "R5", "edges still owed at done", exp_from.size(), 0);
            done_seen = 1'b1;
         end
      end
   end

   task automatic start_pass(input int src, input int dst, input int sp, input int slack,
                             input int slack_after);
      @(negedge clk);
      cfg_slack = SLACK_W'(slack);
      q_src = NODE_W'(src);
      q_dst = NODE_W'(dst);
      q_sp_hops = HOP_W'(sp);
      q_start = 1'b1;
      m_src = src;
      m_dst = dst;
      m_lim = (sp + slack > MAX_HOPS) ? MAX_HOPS : sp + slack;
      exp_cnt = 0;
      @(negedge clk);
      q_start = 1'b0;
      cfg_slack = SLACK_W'(slack_after);
      chk(s_ready, "R9", "ready after query start", int'(s_ready), 1);
   endtask

   task automatic send_path(input int p[$], input bit tail);
      int hops;
      bit kept;
      hops = p.size() - 1;
      kept = (p[0] == m_src) && (p[hops] == m_dst) && (hops <= m_lim);
      if (kept) begin
         exp_cnt++;
         for (int i = 0; i < hops; i++) begin
            exp_from.push_back(p[i]);
            exp_to.push_back(p[i+1]);
            exp_last.push_back(int'(i == hops - 1));
         end
      end
      for (int i = 0; i <= hops; i++) begin
         int waits;
         if ($urandom_range(0, 4) == 0) begin
            @(negedge clk);
            s_valid = 1'b0;
         end
         @(negedge clk);
         s_valid = 1'b1;
         s_node  = NODE_W'(p[i]);
         s_first = (i == 0);
         s_last  = (i == hops);
         s_tail  = tail && (i == hops);
         waits = 0;
         while (!s_ready) begin
            @(negedge clk);
            waits++;
         end
         @(posedge clk);
         if (i > 0) chk(waits == 0, "R6", "stall inside a path", waits, 0);
      end
      @(negedge clk);
      s_valid = 1'b0;
      s_first = 1'b0;
      s_last  = 1'b0;
      s_tail  = 1'b0;
      if (!tail) begin
         if (kept && hops > 0) chk(e_valid, "R5", "edges offered after kept path", int'(e_valid), 1);
         else chk(s_ready && !e_valid, "R6", "ready at once after unkept path", int'(s_ready), 1);
      end else if (!(kept && hops > 0)) begin
         chk(pass_done, "R8", "done one cycle after final beat", int'(pass_done), 1);
      end
   endtask

   task automatic wait_done();
      while (!done_seen) @(negedge clk);
      done_seen = 1'b0;
      @(negedge clk);
      chk(!s_ready && !e_valid, "R9", "idle after done", int'(s_ready), 0);
   endtask

   function automatic void make_line(ref int p[$], input int a, input int b, input int nodes);
      p = {};
      p.push_back(a);
      for (int i = 1; i < nodes - 1; i++) p.push_back(100 + i);
      p.push_back(b);
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int p[$];
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!s_ready && !e_valid && !pass_done, "R9", "reset outputs quiet", int'(s_ready), 0);
      chk(cand_count == '0, "R9", "reset count", int'(cand_count), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!s_ready, "R9", "idle before query", int'(s_ready), 0);

      // Pass A: limit 3+2=5; slack drops to 0 after the query (latched value governs, R3)
      start_pass(10, 20, 3, 2, 0);
      p = '{10, 11, 12, 20};            send_path(p, 1'b0);  // kept, R1 R2
      make_line(p, 10, 20, 6);          send_path(p, 1'b0);  // 5 hops, at limit, R3
      make_line(p, 10, 20, 7);          send_path(p, 1'b0);  // 6 hops, over limit, R3
      p = '{11, 12, 20};                send_path(p, 1'b0);  // wrong start, R1
      p = '{10, 12, 21};                send_path(p, 1'b0);  // wrong end, R2
      p = '{10, 20};                    send_path(p, 1'b0);  // one edge
      p = '{10};                        send_path(p, 1'b1);  // single node, end mismatch
      wait_done();

      // Pass B: nothing qualifies -> fallback (R8)
      start_pass(5, 6, 2, 0, 3);
      p = '{5, 7, 8, 6};                send_path(p, 1'b0);
      p = '{6, 5};                      send_path(p, 1'b1);
      wait_done();

      // Pass C: start equals end, zero-hop path counted without edges (R5)
      start_pass(9, 9, 1, 1, 1);
      p = '{9};                         send_path(p, 1'b0);
      p = '{9, 3, 9};                   send_path(p, 1'b0);
      p = '{9, 4, 9};                   send_path(p, 1'b1);  // kept last path: done after drain
      wait_done();

      // Pass D: widened limit 45 exceeds the buffer cap (R4)
      start_pass(1, 2, 30, 15, 15);
      make_line(p, 1, 2, 32);           send_path(p, 1'b0);  // 31 hops kept
      make_line(p, 1, 2, 33);           send_path(p, 1'b1);  // 32 hops dropped, R4
      wait_done();

      finish_run();
   end

endmodule